// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs register transactions on a two-wire station-management bus. It divides the system clock down to produce the management clock (MDC). It drives the data line (MDIO) through a separate output and output-enable pair, and it samples the line when the PHY drives it. Each request is a read or a write of one 16-bit register, chosen by a 5-bit PHY address and a 5-bit register address.

The request side is a valid/ready channel. `req_ready` is high only while no frame is in flight, and the request fields are captured on the cycle where `req_valid` and `req_ready` are both high. A request offered while `req_ready` is low is not taken. The host keeps `req_valid` and the fields held until the handshake, or withdraws the request. The response side has no back-pressure: `rsp_valid` is a single-cycle strobe, and the host must capture `rsp_rdata` and `rsp_err` in that cycle.

Every frame is 64 MDC periods long. It opens with 32 bits of preamble, then the header (start code, opcode, PHY address, register address). A write continues with a driven turnaround and the data. A read hands the line to the PHY, checks that the PHY pulls it low, and then shifts the data in.

Top module: `mdio_frame_master`

## Requirements
- R1: Each frame begins with 32 MDC periods during which `mdio_oe`=1 and `mdio_o`=1.
- R2: After the preamble, 14 header bits follow, each field MSB first: start code 01, opcode (read 10, write 01), the 5-bit PHY address, then the 5-bit register address.
- R3: `mdio_o` and `mdio_oe` never change in a system clock where MDC is high or where MDC has just toggled. Each MDC high phase lasts exactly DIV system clocks.
- R4: A write drives the turnaround pattern 10 after the register address, then the 16 data bits MSB first, with `mdio_oe`=1 for all 64 MDC periods. A write gives exactly 64 MDC rising edges.
- R5: A read drops `mdio_oe` at the start of MDC period 46 (0-based) and keeps it low through period 63. A read gives exactly 64 MDC rising edges.
- R6: A read samples `mdio_i` just before the MDC rising edge of periods 48 to 63 and returns them MSB first on `rsp_rdata`.
- R7: If `mdio_i` is high when sampled in period 47, the read ends with `rsp_err`=1 and `rsp_rdata`=0.
- R8: After the last bit, MDC stays low and `mdio_oe` returns to 1 with no further MDC edge. Whenever `req_ready` is 1, `mdio_oe`=1 and MDC=0.
- R9: A request is accepted only while `req_ready` is 1. `req_ready` drops in the cycle after acceptance. A request offered while busy has no effect on the frame under way and starts no frame afterwards.
- R10: `rsp_valid` pulses for exactly one system clock, in the same cycle that `req_ready` returns high. After reset: MDC=0, `mdio_o`=1, `mdio_oe`=1, `req_ready`=1, `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 16 | Read result (0 on error or write) |
| rsp_err | output | 1 | PHY did not drive turnaround low |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable (1 = block drives) |
| mdio_i | input | 1 | Data line sampled value |

## Verification
The bench models a PHY on the MDC edges and goes after the cases that are easy to get wrong:
- Reads where the PHY leaves the turnaround bit high. A design that ignored the error would return the PHY's data instead of zero.
- Data words of all ones, all zeros and a single low bit. An off-by-one in the data window would shift or drop the LSB.
- The exact slot where the line is released. A design that released it one period late would fight the PHY; one that released it early would clip the register address.
- Requests offered while a frame is in flight. A design that did not gate them would corrupt the frame or run a second one, and the bench counts MDC edges after completion to catch that extra frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;
  localparam int DATA_W = 16;

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TA_WRITE = 2'b10;

  localparam int HDR_BITS  = 2 + 2 + PHY_W + REG_W;
  localparam int TAIL_BITS = 2 + DATA_W;

  typedef struct packed {
    logic              write;
    logic [PHY_W-1:0]  phy;
    logic [REG_W-1:0]  regad;
    logic [DATA_W-1:0] wdata;
  } mdio_req_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} mdio_state_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic slot_start,
  output logic low_end,
  output logic slot_end
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic          phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign mdc        = phase;
  assign slot_start = run && !phase && (cnt == '0);
  assign low_end    = run && !phase && (cnt == LAST);
  assign slot_end   = run &&  phase && (cnt == LAST);
endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  mdio_req_t req,
  input  logic      shift_en,
  output logic      bit_out
);
  localparam int FRAME = PRE_BITS + HDR_BITS + TAIL_BITS;

  logic [FRAME-1:0]     sreg;
  logic [TAIL_BITS-1:0] tail;
  logic [1:0]           opcode;

  always_comb begin
    opcode = req.write ? OP_WRITE : OP_READ;
    tail   = req.write ? {TA_WRITE, req.wdata} : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sreg <= '1;
    else if (load)
      sreg <= {{PRE_BITS{1'b1}}, SOF_CODE, opcode, req.phy, req.regad, tail};
    else if (shift_en)
      sreg <= {sreg[FRAME-2:0], 1'b1};
  end

  assign bit_out = sreg[FRAME-1];
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              err_en,
  input  logic              data_en,
  input  logic              mdio_i,
  output logic              err,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err   <= 1'b0;
      shift <= '0;
    end else if (clear) begin
      err   <= 1'b0;
      shift <= '0;
    end else begin
      if (err_en)
        err <= mdio_i;
      if (data_en)
        shift <= {shift[DATA_W-2:0], mdio_i};
    end
  end

  assign rdata = err ? '0 : shift;
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int DIV      = 4,
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int FRAME   = PRE_BITS + HDR_BITS + TAIL_BITS;
  localparam int SW      = $clog2(FRAME);
  localparam logic [SW-1:0] TA_SLOT   = SW'(PRE_BITS + HDR_BITS);
  localparam logic [SW-1:0] ERR_SLOT  = SW'(PRE_BITS + HDR_BITS + 1);
  localparam logic [SW-1:0] DATA_SLOT = SW'(PRE_BITS + HDR_BITS + 2);
  localparam logic [SW-1:0] LAST_SLOT = SW'(FRAME - 1);

  mdio_state_e       state;
  logic [SW-1:0]     slot;
  logic              is_rd;
  logic              run, accept;
  logic              slot_start, low_end, slot_end;
  logic              tx_bit, rx_err;
  logic [DATA_W-1:0] rx_data;
  mdio_req_t         req;

  assign req       = '{write: req_write, phy: req_phy, regad: req_reg, wdata: req_wdata};
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign run       = (state == ST_RUN);

  mdio_mdc_gen #(.DIV(DIV)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(run), .mdc(mdc),
    .slot_start(slot_start), .low_end(low_end), .slot_end(slot_end)
  );

  mdio_tx_shift #(.PRE_BITS(PRE_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept), .req(req),
    .shift_en(slot_end), .bit_out(tx_bit)
  );

  mdio_rx_shift u_rx (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .err_en(low_end && is_rd && (slot == ERR_SLOT)),
    .data_en(low_end && is_rd && (slot >= DATA_SLOT)),
    .mdio_i(mdio_i), .err(rx_err), .rdata(rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      slot      <= '0;
      is_rd     <= 1'b0;
      mdio_o    <= 1'b1;
      mdio_oe   <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            is_rd <= !req_write;
            slot  <= '0;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          // Line updates one clock after MDC falls, never on an MDC edge.
          if (slot_start) begin
            mdio_o  <= tx_bit;
            mdio_oe <= !(is_rd && (slot >= TA_SLOT));
          end
          if (slot_end) begin
            if (slot == LAST_SLOT)
              state <= ST_FIN;
            else
              slot <= slot + 1'b1;
          end
        end
        ST_FIN: begin
          mdio_o    <= 1'b1;
          mdio_oe   <= 1'b1;
          rsp_valid <= 1'b1;
          rsp_err   <= is_rd && rx_err;
          rsp_rdata <= is_rd ? rx_data : '0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
  parameter int DIV = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [15:0] rsp_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  int unsigned hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_len <= 0;
    else if (mdc) hi_len <= hi_len + 1;
    else          hi_len <= 0;
  end

  // R3
  line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc || $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R3
  high_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> (hi_len == DIV));

  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

  // R8
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mdio_oe && !mdc));

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
endmodule

bind mdio_frame_master mdio_frame_master_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/test_mdio_frame_master.sv
`timescale 1ns/1ps
module test_mdio_frame_master;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        rsp_err;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #2 clk = ~clk;

  mdio_frame_master #(.DIV(DIV)) i_mdio_frame_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  int checks = 0;
  int fails  = 0;

  // PHY model: record line at each MDC rise, drive read reply after each fall.
  int    idx = 0;
  logic  mo [64];
  logic  moe[64];
  logic  phy_err = 1'b0;
  logic [15:0] phy_data = '0;

  always @(posedge mdc) begin
    if (idx < 64) begin
      mo[idx]  = mdio_o;
      moe[idx] = mdio_oe;
    end
    idx = idx + 1;
  end

  always @(negedge mdc) begin
    if (idx == 47)                  mdio_i = phy_err;
    else if (idx >= 48 && idx < 64) mdio_i = phy_data[63 - idx];
    else                            mdio_i = 1'b1;
  end

  // R3: high phase length measured on the system clock
  int hi_run = 0;
  int r3_bad = 0;
  always @(negedge clk) begin
    if (mdc) hi_run = hi_run + 1;
    else begin
      if (hi_run != 0 && hi_run != DIV) r3_bad = r3_bad + 1;
      hi_run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // {write, phy_err, phy[5], reg[5], wdata[16], phy_data[16]}
  localparam int NV = 7;
  localparam logic [43:0] VEC [NV] = '{
    {1'b1, 1'b0, 5'h01, 5'h00, 16'h1234, 16'h0000},
    {1'b1, 1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000},
    {1'b1, 1'b0, 5'h00, 5'h00, 16'h0000, 16'h0000},
    {1'b0, 1'b0, 5'h03, 5'h02, 16'h0000, 16'hA5C3},
    {1'b0, 1'b0, 5'h1F, 5'h10, 16'h0000, 16'hFFFF},
    {1'b0, 1'b1, 5'h0A, 5'h15, 16'h0000, 16'hBEEF},
    {1'b0, 1'b0, 5'h00, 5'h01, 16'h0000, 16'hFFFE}
  };

  task automatic run_txn(input logic [43:0] v, input bit intrude);
    logic        wr, er;
    logic [4:0]  ph, rg;
    logic [15:0] wd, pd;
    logic [63:0] ef, cap, oecap;
    logic        got_err;
    logic [15:0] got_data;
    int          n;
    wr = v[43]; er = v[42]; ph = v[41:37]; rg = v[36:32];
    wd = v[31:16]; pd = v[15:0];
    ef = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), ph, rg, 2'b10, wd};
    phy_err = er; phy_data = pd; idx = 0;

    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_write = wr; req_phy = ph; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 ready low after accept", 64'(req_ready), 64'd0);

    if (intrude) begin
      repeat (60) @(negedge clk);
      req_valid = 1'b1; req_write = !wr; req_phy = ~ph; req_reg = ~rg; req_wdata = ~wd;
      repeat (5) @(negedge clk);
      req_valid = 1'b0;
    end

    n = 0;
    while (!rsp_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    got_err = rsp_err; got_data = rsp_rdata;
    chk(rsp_valid == 1'b1, "R10 done seen", 64'(rsp_valid), 64'd1);
    chk(req_ready && mdio_oe && !mdc, "R8 line handed back at done",
        {61'd0, req_ready, mdio_oe, mdc}, 64'd6);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 done one cycle", 64'(rsp_valid), 64'd0);
    repeat (4 * DIV) @(negedge clk);

    for (int i = 0; i < 64; i++) begin
      cap[63 - i]   = mo[i];
      oecap[63 - i] = moe[i];
    end
    chk(cap[63:32] == 32'hFFFF_FFFF, "R1 preamble", 64'(cap[63:32]), 64'hFFFF_FFFF);
    chk(oecap[63:32] == 32'hFFFF_FFFF, "R1 preamble driven", 64'(oecap[63:32]), 64'hFFFF_FFFF);
    chk(cap[31:18] == ef[31:18], "R2 header", 64'(cap[31:18]), 64'(ef[31:18]));
    if (wr) begin
      chk(idx == 64, "R4 write edge count", 64'(idx), 64'd64);
      chk(cap[17:0] == ef[17:0], "R4 turnaround and data", 64'(cap[17:0]), 64'(ef[17:0]));
      chk(oecap == '1, "R4 driven throughout", oecap, '1);
      chk(got_err == 1'b0 && got_data == '0, "R4 write response", {47'd0, got_err, got_data}, 64'd0);
    end else begin
      chk(idx == 64, "R5 read edge count", 64'(idx), 64'd64);
      chk(oecap == 64'hFFFF_FFFF_FFFC_0000, "R5 release window", oecap, 64'hFFFF_FFFF_FFFC_0000);
      if (er) begin
        chk(got_err == 1'b1, "R7 error flag", 64'(got_err), 64'd1);
        chk(got_data == '0, "R7 data forced zero", 64'(got_data), 64'd0);
      end else begin
        chk(got_err == 1'b0, "R6 no error", 64'(got_err), 64'd0);
        chk(got_data == pd, "R6 read data", 64'(got_data), 64'(pd));
      end
    end
    if (intrude)
      chk(idx == 64, "R9 busy request ignored", 64'(idx), 64'd64);
    chk(r3_bad == 0, "R3 high phase length", 64'(r3_bad), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({mdc, mdio_o, mdio_oe, req_ready, rsp_valid} == 5'b01110, "R10 reset state",
        {59'd0, mdc, mdio_o, mdio_oe, req_ready, rsp_valid}, 64'b01110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(idx == 0, "R8 no MDC edge while idle", 64'(idx), 64'd0);

    for (int k = 0; k < NV; k++) run_txn(VEC[k], 1'b0);

    // Corner cases: busy requests, and a read with no PHY reply (line idles high)
    run_txn({1'b1, 1'b0, 5'h15, 5'h0A, 16'h8001, 16'h0000}, 1'b1);
    run_txn({1'b0, 1'b0, 5'h11, 5'h03, 16'h0000, 16'h7FFF}, 1'b1);
    run_txn({1'b0, 1'b1, 5'h1E, 5'h1E, 16'h0000, 16'h0000}, 1'b0);

    finish_run();
  end
endmodule